// File: doc/BRIEF.md
# Extended-Range Programmable Integer Divider

This block is a cycle-accurate digital model of the integer part of a fractional-N feedback divider. A fixed divide-by-4 prescaler produces one advance every four fast clocks. That advance clocks a cascade of five divide-by-2/3 cells. Each cell normally divides by two. It swallows one extra input pulse in a period when its control bit is set and the modulus signal from the cell above it is active. Extension logic picks the highest active cell from the most significant set bit of the ratio word. That cell's modulus input is forced active and every cell above it is bypassed, so the chain ratio N covers 4 to 63 instead of only 32 to 63.

The ratio word normally comes from a sigma-delta modulator and may change on every period. The block samples the word only at the end of a period, so each period uses exactly one ratio. Each output period lasts 4×N fast clocks. A one-cycle modulus pulse marks the end of every period. A divided clock output is high while the top active cell is in its final count.

Top module: `ext_div_chain`

## Requirements
- R1: The chain advances only once per four fast clocks. Every modulus pulse is in the cycle right after a prescaler advance.
- R2: With a steady ratio N in 4..63, consecutive rising edges of mod_o are exactly 4×N fast clock cycles apart.
- R3: A ratio word below 4 (values 0, 1, 2 and 3) is treated as 4, giving a period of 16 fast clocks.
- R4: The ratio word is sampled on the clock edge where mod_o rises, and it sets the length of the period that then starts. Changes to ratio_i at any other time have no effect on the current period, even when the word changes every period.
- R5: mod_o is high for exactly one fast clock cycle per period.
- R6: During reset and right after it, mod_o and div_clk_o are low. The first period after reset uses RST_RATIO (default 4), so the first mod_o rises on the 4×RST_RATIO-th clock edge after reset is released.
- R7: Let k be the bit position of the most significant set bit of N. In each period div_clk_o rises exactly once. It stays high for 4×(2^(k-1) + (N mod 2^(k-1))) fast clocks and falls on the same edge where mod_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast divider input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | NUM_CELLS+1 | Chain ratio word N, sampled at each period end |
| div_clk_o | output | 1 | Divided clock, high during the top active cell's final count |
| mod_o | output | 1 | One-cycle end-of-period pulse |

## Verification
The assertions check the following on every cycle:
- mod_o lasts one cycle and follows a prescaler advance.
- div_clk_o is low whenever mod_o pulses, and it only falls together with it.
- The latched ratio changes only at a period end and never drops below 4.
- The gap between pulses stays between 16 and the largest legal period.

Only the bench scenarios can show the exact period length for every ratio from 4 to 63, the clamping of small words, the high time of the divided clock and the sampling point of a ratio that changes every period. They do this by measuring each period against values computed independently.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned MIN_RATIO = 4;
  typedef logic [1:0] cell_cnt_t;
endpackage

// File: rtl/dc_prescale.sv
module dc_prescale #(
  parameter int unsigned PRE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = &cnt_q;
endmodule

// File: rtl/dc_cell.sv
module dc_cell
  import dc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ev_i,
  input  logic ctrl_i,
  input  logic mod_in_i,
  output logic ev_o,
  output logic mod_o
);
  cell_cnt_t cnt_q;
  cell_cnt_t last;
  logic      final_cnt;

  // divide by 3 only when swallow is enabled and the upper chain is in its last run
  assign last      = (ctrl_i && mod_in_i) ? 2'd2 : 2'd1;
  assign final_cnt = (cnt_q >= last);
  assign ev_o      = active_i & ev_i & final_cnt;
  assign mod_o     = active_i & mod_in_i & final_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (ev_i)      cnt_q <= final_cnt ? 2'd0 : cnt_q + 2'd1;
  end
endmodule

// File: rtl/dc_ratio_ctrl.sv
module dc_ratio_ctrl
  import dc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 5,
  parameter int unsigned RST_RATIO = 4,
  localparam int unsigned RATIO_W  = NUM_CELLS + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [NUM_CELLS-1:0] active_o,
  output logic [NUM_CELLS-1:0] last_o,
  output logic [NUM_CELLS-1:0] ctrl_o
);
  localparam logic [RATIO_W-1:0] MinR = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] RstR = RATIO_W'(RST_RATIO);

  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] ratio_clamped;

  assign ratio_clamped = (ratio_i < MinR) ? MinR : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_q <= (RstR < MinR) ? MinR : RstR;
    else if (load_i) ratio_q <= ratio_clamped;
  end

  assign ratio_o = ratio_q;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_dec
    assign active_o[i] = |ratio_q[RATIO_W-1:i+1];
    assign ctrl_o[i]   = ratio_q[i];
    if (i == NUM_CELLS - 1) begin : g_top
      assign last_o[i] = active_o[i];
    end else begin : g_mid
      assign last_o[i] = active_o[i] & ~active_o[i+1];
    end
  end
endmodule

// File: rtl/ext_div_chain.sv
module ext_div_chain #(
  parameter int unsigned NUM_CELLS = 5,
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned RST_RATIO = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CELLS:0]   ratio_i,
  output logic                 div_clk_o,
  output logic                 mod_o
);
  localparam int unsigned RATIO_W = NUM_CELLS + 1;

  logic                 pre_tick;
  logic [RATIO_W-1:0]   ratio_q;
  logic [NUM_CELLS-1:0] active, last, ctrl;
  logic [NUM_CELLS-1:0] ev_in, ev_out, mod_up, mod_dn;
  logic                 period_end;
  logic                 mod_q;

  dc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  dc_ratio_ctrl #(.NUM_CELLS(NUM_CELLS), .RST_RATIO(RST_RATIO)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (period_end),
    .ratio_i  (ratio_i),
    .ratio_o  (ratio_q),
    .active_o (active),
    .last_o   (last),
    .ctrl_o   (ctrl)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_ev0
      assign ev_in[i] = pre_tick;
    end else begin : g_evn
      assign ev_in[i] = ev_out[i-1];
    end
    // top active cell sees a permanently active modulus input
    if (i == NUM_CELLS - 1) begin : g_mtop
      assign mod_dn[i] = 1'b1;
    end else begin : g_mmid
      assign mod_dn[i] = last[i] | mod_up[i+1];
    end

    dc_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active[i]),
      .ev_i     (ev_in[i]),
      .ctrl_i   (ctrl[i]),
      .mod_in_i (mod_dn[i]),
      .ev_o     (ev_out[i]),
      .mod_o    (mod_up[i])
    );
  end

  assign period_end = |(ev_out & last);
  assign div_clk_o  = |(mod_up & last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_q <= 1'b0;
    else         mod_q <= period_end;
  end

  assign mod_o = mod_q;
endmodule

// File: rtl/dc_chain_checker.sv
module dc_chain_checker #(
  parameter int unsigned RATIO_W = 6,
  parameter int unsigned PRE_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mod_o,
  input logic               div_clk_o,
  input logic               pre_tick,
  input logic [RATIO_W-1:0] ratio_q
);
  localparam int unsigned MaxGap = (1 << PRE_W) * ((1 << RATIO_W) - 1);
  localparam int unsigned MinGap = (1 << PRE_W) * 4 - 1;

  logic [15:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gap_q <= '0;
    else if (mod_o) gap_q <= '0;
    else            gap_q <= gap_q + 16'd1;
  end

  a_r1_mod_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |-> $past(pre_tick));
  a_r2_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < 16'(MaxGap));
  a_r3_ratio_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= RATIO_W'(4));
  a_r3_min_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |-> gap_q >= 16'(MinGap));
  a_r4_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> mod_o);
  a_r5_mod_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |=> !mod_o);
  a_r7_div_low_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |-> !div_clk_o);
  a_r7_fall_with_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_clk_o) |-> mod_o);
endmodule

bind ext_div_chain dc_chain_checker #(.RATIO_W(RATIO_W), .PRE_W(PRE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mod_o     (mod_o),
  .div_clk_o (div_clk_o),
  .pre_tick  (pre_tick),
  .ratio_q   (ratio_q)
);

// File: tb/ext_div_chain_tb_top.sv
module ext_div_chain_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] ratio_i;
  logic       div_clk_o, mod_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  ext_div_chain dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ratio_i   (ratio_i),
    .div_clk_o (div_clk_o),
    .mod_o     (mod_o)
  );

  function automatic int clamp_n(int n);
    return (n < 4) ? 4 : n;
  endfunction

  function automatic int high_w(int n);
    int k = 0;
    for (int b = 0; b < 6; b++) if (n[b]) k = b;
    return (1 << (k - 1)) + (n % (1 << (k - 1)));
  endfunction

  function automatic int sched(int p);
    if (p < 60) return 4 + p;
    if (p < 64) return p - 60;
    if (p < 68) return (p == 64) ? 63 : (p == 65) ? 0 : (p == 66) ? 8 : 3;
    if (p < 72) return 37;
    return int'($urandom % 64);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int  cyc = 0, hi = 0, rises = 0, p = 1, exp_n = 4;
    bit  prev_div = 0, prev_mod = 0;
    string tag = "R6";
    void'($urandom(32'd20240611));
    ratio_i = 6'(sched(0));
    repeat (3) @(negedge clk_i);
    check(mod_o == 1'b0, "R6", int'(mod_o), 0);
    check(div_clk_o == 1'b0, "R6", int'(div_clk_o), 0);
    rst_ni = 1'b1;
    while (p < 132) begin
      @(negedge clk_i);
      cyc++;
      if (prev_mod) check(mod_o == 1'b0, "R5", int'(mod_o), 0);
      if (div_clk_o) hi++;
      if (div_clk_o && !prev_div) rises++;
      prev_div = div_clk_o;
      prev_mod = mod_o;
      if (mod_o) begin
        check(cyc == 4 * exp_n, tag, cyc, 4 * exp_n);
        check(hi == 4 * high_w(exp_n), "R7", hi, 4 * high_w(exp_n));
        check(rises == 1, "R7", rises, 1);
        check(div_clk_o == 1'b0, "R7", int'(div_clk_o), 0);
        // R3 small words, R4 word changed this period, R2 steady word
        if (int'(ratio_i) < 4)                tag = "R3";
        else if (int'(ratio_i) != exp_n)      tag = "R4";
        else                                  tag = "R2";
        exp_n = clamp_n(int'(ratio_i));
        cyc = 0; hi = 0; rises = 0;
        ratio_i = 6'(sched(p));
        p++;
      end
      if (cyc > 4 * 64 + 4) begin
        check(1'b0, "R1 watchdog", cyc, 4 * exp_n);
        break;
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule